// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog with a small register file on a fast bus clock and a down-counter on a slow real-time clock. Software loads a 32-bit start count and a 32-bit warning threshold. Each value is written as two 16-bit halves. The write of the threshold's low half commits the pair to the slow domain. While that transfer is in flight, a busy bit in the status register reads 1.

Once the count enable is set, the counter steps down by one on every slow-clock edge. When it steps onto the threshold, a warning flag is set. When it steps onto zero, a reset flag is set and the counter stays at zero. The flags drive a pre-timeout interrupt and a reset request, each through its own enable. The interrupt also passes through a mask.

Every write except one to the lock register is dropped until the unlock key has been written. The block assumes the bus clock runs at least four times faster than the slow clock.

Top module: `wdg_dual_stage`

## Requirements
- R1: After reset the block is locked. All readable registers return 0, and both outputs are low.
- R2: Writing a value whose bits 15:0 are 0xE551 to offset 0x20 unlocks the block, and writing any other value there locks it. Offset 0x20 reads 1 in bit 0 while unlocked. While locked, writes to every other offset change nothing.
- R3: The start count is written at offsets 0x00 (low half) and 0x04 (high half), and the threshold at 0x2C (low) and 0x30 (high). Each reads back only bits 15:0. Control at 0x08 keeps bits 3:0: bit 0 interrupt enable, bit 1 count enable, bit 2 a stored mode bit with no other effect, bit 3 reset enable. The mask at 0x14 keeps bit 0. Unused bits read 0. Read data is valid in the cycle after the read strobe.
- R4: An unlocked write to 0x2C commits the start count and the threshold. Status bit 4 reads 1 from the next cycle and returns to 0 within three slow periods plus three bus cycles. A commit made while busy is dropped.
- R5: After a commit, the live count equals the start count. It drops by one per slow cycle while count enable is 1, stays at zero once there, and holds its value while count enable is 0.
- R6: A read of 0x1C returns the count's high half and captures its low half. Reads of 0x18 return that captured low half until the next read of 0x1C.
- R7: Status bit 0 (warning flag) is set when the counter steps onto the threshold. On a full run from start count S, it ends set exactly when threshold < S.
- R8: Status bit 3 (expiry flag) is set when the counter steps onto zero. On a full run, it ends set exactly when S is not 0.
- R9: An unlocked write to 0x0C with bit 0 set clears the warning flag, and one with bit 3 set clears the expiry flag. Otherwise both flags hold.
- R10: `pretimeout_irq` is the warning flag AND interrupt enable AND NOT mask bit 0. `reset_req` is the expiry flag AND reset enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset, bus domain |
| slow_clk | input | 1 | Slow real-time counting clock |
| slow_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| pretimeout_irq | output | 1 | Warning interrupt |
| reset_req | output | 1 | Expiry reset request |

## Verification
Register writes and the busy bit take effect one bus cycle after the strobe, and read data lands one bus cycle after its strobe. The bench therefore samples at the next falling edge. A commit reaches the counter two to three slow edges later, and counter results reach the bus side a further two or three bus cycles after that. Slow-domain results are therefore checked only after a wait counted in whole slow periods with margin. Busy is polled against its bound. The counter is frozen through its enable before any exact count comparison, so no check depends on where a slow edge falls relative to the bus clock.

// File: rtl/wdg_pkg.sv
// Shared offsets, key, status bit positions and control layout for the
// two-stage watchdog. Assumes 32-bit aligned byte offsets on a 6-bit bus.
package wdg_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_RLD_LO = 6'h00;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 6'h04;
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h08;
    localparam logic [ADDR_W-1:0] A_CLR    = 6'h0C;
    localparam logic [ADDR_W-1:0] A_STAT   = 6'h10;
    localparam logic [ADDR_W-1:0] A_MASK   = 6'h14;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 6'h18;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 6'h1C;
    localparam logic [ADDR_W-1:0] A_LOCK   = 6'h20;
    localparam logic [ADDR_W-1:0] A_THR_LO = 6'h2C;
    localparam logic [ADDR_W-1:0] A_THR_HI = 6'h30;

    localparam logic [15:0] UNLOCK_KEY = 16'hE551;

    localparam int B_WARN = 0;
    localparam int B_EXP  = 3;
    localparam int B_BUSY = 4;

    typedef struct packed {
        logic rst_en;
        logic mode_sel;
        logic cnt_en;
        logic int_en;
    } wdg_ctrl_t;
endpackage

// File: rtl/wdg_sync.sv
// Single-bit multi-stage synchronizer into the destination clock domain.
// Assumes the input is a level or a toggle that holds for several
// destination cycles.
module wdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdg_regs.sv
// Bus-side register file: key lock, start/threshold halves, control, mask,
// sticky flags, count snapshot and registered read mux.
// Assumes flag events arrive as single-cycle pulses in the bus domain.
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              busy_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ev_warn_i,
    input  logic              ev_exp_i,
    output logic              commit_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CNT_W-1:0]  thr_new_o,
    output logic [CNT_W-1:0]  thr_q_o,
    output wdg_ctrl_t         ctrl_o,
    output logic              mask_o,
    output logic              unlocked_o,
    output logic              warn_o,
    output logic              exp_o
);
    localparam int HW = CNT_W / 2;

    logic          unlocked_q;
    logic [HW-1:0] rld_lo_q, rld_hi_q, thr_lo_q, thr_hi_q, snap_lo_q;
    wdg_ctrl_t     ctrl_q;
    logic          mask_q, warn_q, exp_q;
    logic [DW-1:0] rdata_q, rd_mux;
    logic          wr_ok, clr_warn, clr_exp;
    logic          unused_wdata;

    assign wr_ok        = bus_we && unlocked_q;
    assign clr_warn     = wr_ok && (bus_addr == A_CLR) && bus_wdata[B_WARN];
    assign clr_exp      = wr_ok && (bus_addr == A_CLR) && bus_wdata[B_EXP];
    assign unused_wdata = ^bus_wdata[DW-1:16];

    // Key register: the matching key opens, any other value closes.
    always_ff @(posedge clk) begin
        if (!rst_n)                            unlocked_q <= 1'b0;
        else if (bus_we && bus_addr == A_LOCK) unlocked_q <= (bus_wdata[15:0] == UNLOCK_KEY);
    end

    // Configuration registers, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_lo_q <= '0;
            rld_hi_q <= '0;
            thr_lo_q <= '0;
            thr_hi_q <= '0;
            ctrl_q   <= '0;
            mask_q   <= 1'b0;
        end else if (wr_ok) begin
            case (bus_addr)
                A_RLD_LO: rld_lo_q <= bus_wdata[HW-1:0];
                A_RLD_HI: rld_hi_q <= bus_wdata[HW-1:0];
                A_THR_LO: thr_lo_q <= bus_wdata[HW-1:0];
                A_THR_HI: thr_hi_q <= bus_wdata[HW-1:0];
                A_CTRL:   ctrl_q   <= wdg_ctrl_t'(bus_wdata[3:0]);
                A_MASK:   mask_q   <= bus_wdata[0];
                default:  ;
            endcase
        end
    end

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_q <= 1'b0;
            exp_q  <= 1'b0;
        end else begin
            warn_q <= ev_warn_i || (warn_q && !clr_warn);
            exp_q  <= ev_exp_i  || (exp_q  && !clr_exp);
        end
    end

    // Read multiplexer over all offsets; unused bits read zero.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_RLD_LO: rd_mux = DW'(rld_lo_q);
            A_RLD_HI: rd_mux = DW'(rld_hi_q);
            A_THR_LO: rd_mux = DW'(thr_lo_q);
            A_THR_HI: rd_mux = DW'(thr_hi_q);
            A_CTRL:   rd_mux = DW'(ctrl_q);
            A_MASK:   rd_mux = DW'(mask_q);
            A_LOCK:   rd_mux = DW'(unlocked_q);
            A_CNT_LO: rd_mux = DW'(snap_lo_q);
            A_CNT_HI: rd_mux = DW'(cnt_i[CNT_W-1:HW]);
            A_STAT: begin
                rd_mux[B_WARN] = warn_q;
                rd_mux[B_EXP]  = exp_q;
                rd_mux[B_BUSY] = busy_i;
            end
            default:  rd_mux = '0;
        endcase
    end

    // Register the read data and capture the low half on a high-half read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            snap_lo_q <= '0;
        end else if (bus_re) begin
            rdata_q <= rd_mux;
            if (bus_addr == A_CNT_HI) snap_lo_q <= cnt_i[HW-1:0];
        end
    end

    assign bus_rdata  = rdata_q;
    assign commit_o   = wr_ok && (bus_addr == A_THR_LO);
    assign reload_o   = {rld_hi_q, rld_lo_q};
    assign thr_new_o  = {thr_hi_q, bus_wdata[HW-1:0]};
    assign thr_q_o    = {thr_hi_q, thr_lo_q};
    assign ctrl_o     = ctrl_q;
    assign mask_o     = mask_q;
    assign unlocked_o = unlocked_q;
    assign warn_o     = warn_q;
    assign exp_o      = exp_q;
endmodule

// File: rtl/wdg_xfer.sv
// Bus-side half of the clock crossing: holds committed values behind a
// request toggle, derives busy from the returned acknowledge, and mirrors
// the slow counter and its events on each published toggle.
// Assumes the bus clock is at least four times the slow clock.
module wdg_xfer #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             ack_tgl_i,
    input  logic             pub_tgl_i,
    input  logic [CNT_W-1:0] pub_cnt_i,
    input  logic             pub_warn_i,
    input  logic             pub_exp_i,
    output logic             req_tgl_o,
    output logic [CNT_W-1:0] hold_reload_o,
    output logic [CNT_W-1:0] hold_thr_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ev_warn_o,
    output logic             ev_exp_o
);
    logic             req_q, ack_s, pub_s, pub_seen_q;
    logic [CNT_W-1:0] hold_rld_q, hold_thr_q, cnt_q;
    logic             ev_warn_q, ev_exp_q;

    wdg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_tgl_i), .q(ack_s));
    wdg_sync #(.STAGES(SYNC_STAGES)) u_pub_sync (
        .clk(clk), .rst_n(rst_n), .d(pub_tgl_i), .q(pub_s));

    assign busy_o = req_q ^ ack_s;

    // Latch a commit and flip the request, unless one is still in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q      <= 1'b0;
            hold_rld_q <= '0;
            hold_thr_q <= '0;
        end else if (commit_i && !busy_o) begin
            req_q      <= ~req_q;
            hold_rld_q <= reload_i;
            hold_thr_q <= thr_i;
        end
    end

    // Capture the published count and events once per slow cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_seen_q <= 1'b0;
            cnt_q      <= '0;
            ev_warn_q  <= 1'b0;
            ev_exp_q   <= 1'b0;
        end else if (pub_s != pub_seen_q) begin
            pub_seen_q <= pub_s;
            cnt_q      <= pub_cnt_i;
            ev_warn_q  <= pub_warn_i;
            ev_exp_q   <= pub_exp_i;
        end else begin
            ev_warn_q  <= 1'b0;
            ev_exp_q   <= 1'b0;
        end
    end

    assign req_tgl_o     = req_q;
    assign hold_reload_o = hold_rld_q;
    assign hold_thr_o    = hold_thr_q;
    assign cnt_o         = cnt_q;
    assign ev_warn_o     = ev_warn_q;
    assign ev_exp_o      = ev_exp_q;
endmodule

// File: rtl/wdg_core.sv
// Slow-domain counter: takes committed values on a synchronized request,
// counts down while enabled, stops at zero, flags threshold and zero
// crossings and publishes its state with a free-running toggle.
// Assumes held values are stable while a request is outstanding.
module wdg_core #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             slow_clk,
    input  logic             slow_rst_n,
    input  logic             req_tgl_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             cnt_en_i,
    output logic             ack_tgl_o,
    output logic             pub_tgl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ev_warn_o,
    output logic             ev_exp_o,
    output logic             load_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             req_s, en_s, seen_q, pub_q, warn_q, exp_q;
    logic [CNT_W-1:0] cnt_q, thr_q, cnt_dec;
    logic             load;

    wdg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl_i), .q(req_s));
    wdg_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(cnt_en_i), .q(en_s));

    assign load    = req_s ^ seen_q;
    assign cnt_dec = cnt_q - ONE;

    // Load, decrement or hold the count and mark the crossings.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) begin
            cnt_q  <= '0;
            thr_q  <= '0;
            seen_q <= 1'b0;
            warn_q <= 1'b0;
            exp_q  <= 1'b0;
        end else if (load) begin
            cnt_q  <= reload_i;
            thr_q  <= thr_i;
            seen_q <= req_s;
            warn_q <= 1'b0;
            exp_q  <= 1'b0;
        end else if (en_s && cnt_q != '0) begin
            cnt_q  <= cnt_dec;
            warn_q <= (cnt_dec == thr_q);
            exp_q  <= (cnt_dec == '0);
        end else begin
            warn_q <= 1'b0;
            exp_q  <= 1'b0;
        end
    end

    // Flip the publish toggle every slow cycle.
    always_ff @(posedge slow_clk) begin
        if (!slow_rst_n) pub_q <= 1'b0;
        else             pub_q <= ~pub_q;
    end

    assign ack_tgl_o = seen_q;
    assign pub_tgl_o = pub_q;
    assign cnt_o     = cnt_q;
    assign ev_warn_o = warn_q;
    assign ev_exp_o  = exp_q;
    assign load_o    = load;
endmodule

// File: rtl/wdg_dual_stage.sv
// Top of the lockable two-stage watchdog: bus register file, crossing
// logic and slow counter. Assumes clk is at least four times slow_clk.
module wdg_dual_stage
    import wdg_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              slow_rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              pretimeout_irq,
    output logic              reset_req
);
    logic             commit, busy, unlocked, warn_flag, exp_flag, mask0;
    logic             ev_warn, ev_exp, req_tgl, ack_tgl, pub_tgl;
    logic             s_warn, s_exp, load_s;
    logic [CNT_W-1:0] reload_q, thr_new, thr_q, hold_rld, hold_thr;
    logic [CNT_W-1:0] cnt_mirror, cnt_s;
    wdg_ctrl_t        ctrl_q;

    wdg_regs #(.CNT_W(CNT_W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy_i(busy), .cnt_i(cnt_mirror),
        .ev_warn_i(ev_warn), .ev_exp_i(ev_exp),
        .commit_o(commit), .reload_o(reload_q), .thr_new_o(thr_new),
        .thr_q_o(thr_q), .ctrl_o(ctrl_q), .mask_o(mask0),
        .unlocked_o(unlocked), .warn_o(warn_flag), .exp_o(exp_flag));

    wdg_xfer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .reload_i(reload_q), .thr_i(thr_new),
        .ack_tgl_i(ack_tgl), .pub_tgl_i(pub_tgl), .pub_cnt_i(cnt_s),
        .pub_warn_i(s_warn), .pub_exp_i(s_exp),
        .req_tgl_o(req_tgl), .hold_reload_o(hold_rld), .hold_thr_o(hold_thr),
        .busy_o(busy), .cnt_o(cnt_mirror),
        .ev_warn_o(ev_warn), .ev_exp_o(ev_exp));

    wdg_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .req_tgl_i(req_tgl), .reload_i(hold_rld), .thr_i(hold_thr),
        .cnt_en_i(ctrl_q.cnt_en),
        .ack_tgl_o(ack_tgl), .pub_tgl_o(pub_tgl), .cnt_o(cnt_s),
        .ev_warn_o(s_warn), .ev_exp_o(s_exp), .load_o(load_s));

    assign pretimeout_irq = warn_flag && ctrl_q.int_en && !mask0;
    assign reset_req      = exp_flag && ctrl_q.rst_en;
endmodule

// File: rtl/wdg_chk.sv
// Property checker for the watchdog, bound to the top module.
module wdg_chk
    import wdg_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DW    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slow_clk,
    input logic              slow_rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              unlocked,
    input logic              commit,
    input logic              busy,
    input logic              warn_flag,
    input logic              exp_flag,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  thr_q,
    input logic              load_s,
    input logic [CNT_W-1:0]  cnt_s
);
    a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_we && bus_addr != A_LOCK) |=> ($stable(reload_q) && $stable(thr_q)));

    a_r4_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !busy) |=> busy);

    a_r9_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_flag && !(unlocked && bus_we && bus_addr == A_CLR && bus_wdata[B_WARN])) |=> warn_flag);

    a_r9_exp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_flag && !(unlocked && bus_we && bus_addr == A_CLR && bus_wdata[B_EXP])) |=> exp_flag);

    a_r5_no_increment: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        !load_s |=> (cnt_s <= $past(cnt_s)));
endmodule

bind wdg_dual_stage wdg_chk #(.CNT_W(CNT_W), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .unlocked(unlocked), .commit(commit), .busy(busy),
    .warn_flag(warn_flag), .exp_flag(exp_flag),
    .reload_q(reload_q), .thr_q(thr_q), .load_s(load_s), .cnt_s(cnt_s));

// File: tb/wdg_dual_stage_tb.sv
module wdg_dual_stage_tb;
    import wdg_pkg::*;

    logic        clk = 1'b0, slow_clk = 1'b0;
    logic        rst_n = 1'b0, slow_rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pretimeout_irq, reset_req;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2  clk = ~clk;
    always #20 slow_clk = ~slow_clk;

    wdg_dual_stage u_dut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pretimeout_irq(pretimeout_irq), .reset_req(reset_req));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_slow(input int n);
        repeat (n) @(negedge slow_clk);
        @(negedge clk);
    endtask

    // Poll status until busy drops; returns bus cycles spent.
    task automatic wait_idle(output int cyc);
        logic [31:0] s;
        cyc = 0;
        do begin
            rd(A_STAT, s);
            cyc += 2;
        end while (s[B_BUSY] && cyc < 80);
    endtask

    task automatic read_cnt(output logic [31:0] c);
        logic [31:0] hi, lo;
        rd(A_CNT_HI, hi);
        rd(A_CNT_LO, lo);
        c = {hi[15:0], lo[15:0]};
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            report();
        end
    end

    initial begin
        logic [31:0] d, c1, c2, lo1, lo2;
        int cyc;

        repeat (4) @(negedge slow_clk);
        @(negedge clk);
        rst_n = 1'b1; slow_rst_n = 1'b1;
        wait_slow(2);

        // R1 reset state
        rd(A_STAT, d);   chk("R1 status", d, 32'h0);
        rd(A_CTRL, d);   chk("R1 ctrl", d, 32'h0);
        rd(A_LOCK, d);   chk("R1 lock", d, 32'h0);
        rd(A_RLD_LO, d); chk("R1 reload", d, 32'h0);
        read_cnt(d);     chk("R1 count", d, 32'h0);
        chk("R1 outputs", {30'b0, pretimeout_irq, reset_req}, 32'h0);

        // R2 locked writes dropped
        wr(A_RLD_LO, 32'h0000_1234);
        rd(A_RLD_LO, d); chk("R2 locked reload", d, 32'h0);
        wr(A_CTRL, 32'hF);
        rd(A_CTRL, d);   chk("R2 locked ctrl", d, 32'h0);
        wr(A_LOCK, 32'h0000_E551);
        rd(A_LOCK, d);   chk("R2 unlocked read", d, 32'h1);

        // R3 readback and field widths
        wr(A_RLD_LO, 32'hFFFF_1234);
        wr(A_RLD_HI, 32'h0000_ABCD);
        rd(A_RLD_LO, d); chk("R3 reload lo", d, 32'h1234);
        rd(A_RLD_HI, d); chk("R3 reload hi", d, 32'hABCD);
        wr(A_LOCK, 32'h1);
        rd(A_LOCK, d);   chk("R2 relocked read", d, 32'h0);
        wr(A_RLD_LO, 32'h5555);
        rd(A_RLD_LO, d); chk("R2 relocked reload", d, 32'h1234);
        wr(A_LOCK, 32'hE551);
        wr(A_CTRL, 32'hFFFF_FFF4);
        rd(A_CTRL, d);   chk("R3 ctrl bits", d, 32'h4);
        wr(A_MASK, 32'hFF);
        rd(A_MASK, d);   chk("R3 mask bit", d, 32'h1);
        wr(A_MASK, 32'h0);
        wr(A_THR_HI, 32'hFFFF_0007);
        rd(A_THR_HI, d); chk("R3 thr hi", d, 32'h7);

        // R4 commit, busy and dropped second commit
        wr(A_THR_HI, 32'h0);
        wr(A_RLD_HI, 32'h0);
        wr(A_RLD_LO, 32'h30);
        wr(A_THR_LO, 32'h5);
        rd(A_STAT, d);   chk("R4 busy set", {31'b0, d[B_BUSY]}, 32'h1);
        wr(A_RLD_LO, 32'h99);
        wr(A_THR_LO, 32'h3);
        wait_idle(cyc);
        chk("R4 busy bound", {31'b0, (cyc <= 40)}, 32'h1);
        wait_slow(3);
        read_cnt(d);     chk("R4 R5 loaded count", d, 32'h30);

        // R5 countdown and freeze
        wr(A_RLD_LO, 32'h30);
        wr(A_THR_LO, 32'h10);
        wait_idle(cyc);
        wr(A_CTRL, 32'h2);
        wait_slow(10);
        wr(A_CTRL, 32'h0);
        wait_slow(4);
        read_cnt(c1);
        chk("R5 decremented", {31'b0, (c1 >= 32'h30 - 13 && c1 <= 32'h30 - 7)}, 32'h1);
        wait_slow(5);
        read_cnt(c2);    chk("R5 frozen", c2, c1);

        // R6 snapshot across the half boundary while running
        wr(A_RLD_HI, 32'h1);
        wr(A_RLD_LO, 32'h1);
        wr(A_THR_LO, 32'h0);
        wait_idle(cyc);
        wr(A_CTRL, 32'h2);
        wait_slow(3);
        rd(A_CNT_HI, c1);
        wait_slow(4);
        rd(A_CNT_LO, lo1);
        wait_slow(4);
        rd(A_CNT_LO, lo2);
        chk("R6 low held", lo2, lo1);
        c2 = {c1[15:0], lo1[15:0]};
        chk("R6 consistent", {31'b0, (c2 <= 32'h1_0001 && c2 >= 32'h1_0001 - 8)}, 32'h1);
        wr(A_CTRL, 32'h0);
        wait_slow(4);

        // R7 R8 R10 sweep of start count and threshold
        for (int r = 0; r <= 6; r++) begin
            for (int t = 0; t <= 7; t++) begin
                logic [31:0] exp_st;
                wr(A_CTRL, 32'h0);
                wr(A_CLR, 32'h9);
                wr(A_RLD_HI, 32'h0);
                wr(A_RLD_LO, r);
                wr(A_THR_HI, 32'h0);
                wr(A_THR_LO, t);
                wait_idle(cyc);
                wait_slow(2);
                read_cnt(d);   chk("R5 sweep load", d, r);
                wr(A_CTRL, 32'hB);
                wait_slow(r + 6);
                exp_st = ((t < r) ? 32'h1 : 32'h0) | ((r != 0) ? 32'h8 : 32'h0);
                rd(A_STAT, d); chk("R7 R8 sweep status", d, exp_st);
                read_cnt(d);   chk("R5 sweep stop at zero", d, 32'h0);
                chk("R10 sweep outputs", {30'b0, pretimeout_irq, reset_req},
                    {30'b0, (t < r), (r != 0)});
            end
        end

        // R9 R10 mask, enables and clears
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h9);
        wr(A_RLD_LO, 32'h4);
        wr(A_THR_LO, 32'h2);
        wait_idle(cyc);
        wr(A_CTRL, 32'hB);
        wait_slow(10);
        rd(A_STAT, d);   chk("R7 R8 both flags", d, 32'h9);
        wr(A_MASK, 32'h1);
        chk("R10 masked irq", {31'b0, pretimeout_irq}, 32'h0);
        rd(A_STAT, d);   chk("R10 mask keeps flag", d, 32'h9);
        wr(A_CTRL, 32'h3);
        chk("R10 reset enable off", {31'b0, reset_req}, 32'h0);
        wr(A_CTRL, 32'hB);
        chk("R10 reset enable on", {31'b0, reset_req}, 32'h1);
        wr(A_LOCK, 32'h0);
        wr(A_CLR, 32'h9);
        rd(A_STAT, d);   chk("R2 R9 locked clear", d, 32'h9);
        wr(A_LOCK, 32'hE551);
        wr(A_CLR, 32'h1);
        rd(A_STAT, d);   chk("R9 warn cleared", d, 32'h8);
        wr(A_MASK, 32'h0);
        chk("R10 irq after clear", {31'b0, pretimeout_irq}, 32'h0);
        chk("R9 reset kept", {31'b0, reset_req}, 32'h1);
        wr(A_CLR, 32'h8);
        rd(A_STAT, d);   chk("R9 exp cleared", d, 32'h0);
        chk("R9 R10 reset dropped", {31'b0, reset_req}, 32'h0);

        done = 1'b1;
        report();
    end
endmodule